// File: doc/BRIEF.md
# Push-Button Mode Menu Controller

This block turns four raw push-button levels into a small hierarchical menu. A user picks the system operating mode (genlock, pass-through or standalone), a video format code and a clock-frequency code. Each button passes through a two-flop synchroniser and a counter debouncer, which produce a one-cycle press pulse. A menu state machine consumes these pulses. Eight LEDs give feedback. The active menu is shown by one blinking LED, the current operating mode lights one of three dedicated LEDs, and the result of every commit shows as one (success) or two (failure) flashes of all eight LEDs.

The actual reconfiguration of clocks and serialisers lies outside this block. For a mode change it is represented by the `cfg_ok` input, which is sampled on the press that selects the mode. Format and frequency are edited as pending values. They are committed together only when the system is in standalone mode and the pending pair is compatible. The committed mode, format and frequency appear as plain registered outputs.

Top module: `mode_menu_ctrl`

## Requirements
- R1: After reset the menu is the main menu, `sys_mode` is 2 (standalone), `fmt_code` is 0 and `freq_code` is 0. `led[0]` blinks with a period of 2*BLINK_LEN cycles (BLINK_LEN cycles on, BLINK_LEN off).
- R2: From the main menu, button 0 opens the mode menu, button 1 runs the datapath action, button 2 opens the format menu and button 3 opens the frequency menu. Outside a flash, exactly the LED of the active menu blinks: `led[0]` for main, `led[1]` for mode, `led[2]` for format and `led[3]` for frequency. The other LEDs among `led[3:0]` and `led[4]` stay off.
- R3: Outside a flash, `led[7:5]` is one-hot with the current mode. `led[5]` lights for genlock (code 0), `led[6]` for pass-through (code 1) and `led[7]` for standalone (code 2).
- R4: In the mode menu, button 0 returns to the main menu without a flash. Buttons 1, 2 and 3 select genlock, pass-through and standalone. With `cfg_ok`=1 the mode is updated and one flash follows. With `cfg_ok`=0 the mode is kept and two flashes follow. Either way control returns to the main menu.
- R5: The datapath action changes nothing, gives two flashes and stays in the main menu.
- R6: In the format and frequency menus the buttons act as follows. Button 0 cancels: the pending value of that menu is restored to its committed value and the menu returns to main without a flash. Button 1 is OK. Button 2 steps up and button 3 steps down. Format codes wrap within 0..11 and frequency codes within 0..4.
- R7: OK in either of those menus commits both pending values only when `sys_mode` is standalone and the pair is compatible. Compatible means format 0-1 with frequency 0, format 2-9 with frequency 1 or 2, or format 10-11 with frequency 3 or 4. A commit gives one flash. Otherwise nothing is committed, the pending values are kept and two flashes follow. Control then returns to main.
- R8: Each flash drives all eight LEDs on for FLASH_LEN cycles, then off for FLASH_LEN cycles.
- R9: Press pulses that arrive while a flash sequence runs are discarded.
- R10: A raw button level must differ from the debounced level for DEB_LEN consecutive synchronised cycles before it is taken. Each accepted press yields exactly one pulse, and shorter glitches yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 4 | Raw button levels, 1 = pressed (asynchronous) |
| cfg_ok | input | 1 | Outcome of a mode reconfiguration, sampled on the selecting press |
| led | output | 8 | Menu, mode and flash indication |
| sys_mode | output | 2 | Committed mode: 0 genlock, 1 pass-through, 2 standalone |
| fmt_code | output | 4 | Committed video format code |
| freq_code | output | 3 | Committed clock-frequency code |

## Verification
The hardest situation to reach is a commit from one menu that depends on a pending value left behind by a failed OK in the other menu. The other hard case is a cancel whose effect is visible only through a later OK. The stimulus walks a long press sequence that first fails an incompatible format, then fixes the pair from the frequency menu, and then proves a cancelled frequency edit by re-confirming the old pair. A second button press is timed to land inside a running two-flash sequence, and the check confirms that the menu it would have opened never blinks.

// File: rtl/menu_pkg.sv
package menu_pkg;
  localparam int NUM_BTN  = 4;
  localparam int FMT_W    = 4;
  localparam int FRQ_W    = 3;
  localparam int MODE_W   = 2;
  localparam int LED_W    = 8;
  localparam int FMT_LAST = 11;
  localparam int FRQ_LAST = 4;

  typedef enum logic [1:0] {
    MENU_MAIN = 2'd0,
    MENU_MODE = 2'd1,
    MENU_FMT  = 2'd2,
    MENU_FREQ = 2'd3
  } menu_e;

  localparam logic [MODE_W-1:0] SYS_GENLOCK = 2'd0;
  localparam logic [MODE_W-1:0] SYS_PASS    = 2'd1;
  localparam logic [MODE_W-1:0] SYS_STAND   = 2'd2;

  localparam int B_CANCEL = 0;
  localparam int B_OK     = 1;
  localparam int B_UP     = 2;
  localparam int B_DOWN   = 3;

  function automatic logic pair_ok(logic [FMT_W-1:0] f, logic [FRQ_W-1:0] q);
    if (f <= 4'd1)       return q == 3'd0;
    else if (f <= 4'd9)  return (q == 3'd1) || (q == 3'd2);
    else if (f <= 4'd11) return (q == 3'd3) || (q == 3'd4);
    else                 return 1'b0;
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int CW = (DEB_LEN > 2) ? $clog2(DEB_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_LEN - 1);

  logic [1:0]    sync_q;
  logic          level_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      level_q <= 1'b0;
      cnt_q   <= '0;
      press   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      press  <= 1'b0;
      if (sync_q[1] != level_q) begin
        if (cnt_q == CNT_LAST) begin
          level_q <= sync_q[1];
          cnt_q   <= '0;
          press   <= sync_q[1];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int FLASH_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic two,
  output logic busy,
  output logic lit
);
  localparam int CW = (FLASH_LEN > 2) ? $clog2(FLASH_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FLASH_LEN - 1);

  logic [2:0]    halves_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halves_q <= '0;
      cnt_q    <= '0;
    end else if (go && (halves_q == 3'd0)) begin
      halves_q <= two ? 3'd4 : 3'd2;
      cnt_q    <= '0;
    end else if (halves_q != 3'd0) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q    <= '0;
        halves_q <= halves_q - 3'd1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = (halves_q != 3'd0);
  assign lit  = busy && !halves_q[0];
endmodule

// File: rtl/menu_fsm.sv
module menu_fsm
  import menu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BTN-1:0]    press,
  input  logic                  busy,
  input  logic                  cfg_ok,
  output menu_e                 menu,
  output logic [MODE_W-1:0]     mode_q,
  output logic [FMT_W-1:0]      fmt_q,
  output logic [FRQ_W-1:0]      freq_q,
  output logic                  fl_go,
  output logic                  fl_two
);
  logic [FMT_W-1:0] pf_q;
  logic [FRQ_W-1:0] pq_q;
  logic             take;

  assign take = !busy && !fl_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      menu   <= MENU_MAIN;
      mode_q <= SYS_STAND;
      fmt_q  <= '0;
      freq_q <= '0;
      pf_q   <= '0;
      pq_q   <= '0;
      fl_go  <= 1'b0;
      fl_two <= 1'b0;
    end else begin
      fl_go <= 1'b0;
      if (take) begin
        case (menu)
          MENU_MAIN: begin
            if (press[0])      menu <= MENU_MODE;
            else if (press[1]) begin fl_go <= 1'b1; fl_two <= 1'b1; end
            else if (press[2]) menu <= MENU_FMT;
            else if (press[3]) menu <= MENU_FREQ;
          end
          MENU_MODE: begin
            if (press[B_CANCEL]) begin
              menu <= MENU_MAIN;
            end else if (|press[3:1]) begin
              menu   <= MENU_MAIN;
              fl_go  <= 1'b1;
              fl_two <= !cfg_ok;
              if (cfg_ok)
                mode_q <= press[1] ? SYS_GENLOCK : (press[2] ? SYS_PASS : SYS_STAND);
            end
          end
          MENU_FMT, MENU_FREQ: begin
            if (press[B_CANCEL]) begin
              menu <= MENU_MAIN;
              if (menu == MENU_FMT) pf_q <= fmt_q;
              else                  pq_q <= freq_q;
            end else if (press[B_OK]) begin
              menu  <= MENU_MAIN;
              fl_go <= 1'b1;
              if ((mode_q == SYS_STAND) && pair_ok(pf_q, pq_q)) begin
                fmt_q  <= pf_q;
                freq_q <= pq_q;
                fl_two <= 1'b0;
              end else begin
                fl_two <= 1'b1;
              end
            end else if (press[B_UP]) begin
              if (menu == MENU_FMT)
                pf_q <= (pf_q == FMT_W'(FMT_LAST)) ? '0 : pf_q + 1'b1;
              else
                pq_q <= (pq_q == FRQ_W'(FRQ_LAST)) ? '0 : pq_q + 1'b1;
            end else if (press[B_DOWN]) begin
              if (menu == MENU_FMT)
                pf_q <= (pf_q == '0) ? FMT_W'(FMT_LAST) : pf_q - 1'b1;
              else
                pq_q <= (pq_q == '0) ? FRQ_W'(FRQ_LAST) : pq_q - 1'b1;
            end
          end
          default: menu <= MENU_MAIN;
        endcase
      end
    end
  end
endmodule

// File: rtl/mode_menu_ctrl.sv
module mode_menu_ctrl
  import menu_pkg::*;
#(
  parameter int DEB_LEN   = 20000,
  parameter int BLINK_LEN = 12500000,
  parameter int FLASH_LEN = 6250000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   btn_raw,
  input  logic         cfg_ok,
  output logic [7:0]   led,
  output logic [1:0]   sys_mode,
  output logic [3:0]   fmt_code,
  output logic [2:0]   freq_code
);
  localparam int BW = (BLINK_LEN > 2) ? $clog2(BLINK_LEN) : 1;
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_LEN - 1);

  logic [NUM_BTN-1:0] press;
  logic               fl_busy;
  logic               fl_lit;
  logic               fl_go;
  logic               fl_two;
  menu_e              menu;
  logic [BW-1:0]      blink_cnt;
  logic               blink_on;

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    btn_debounce #(.DEB_LEN(DEB_LEN)) i_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (btn_raw[i]),
      .press (press[i])
    );
  end

  menu_fsm i_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .press  (press),
    .busy   (fl_busy),
    .cfg_ok (cfg_ok),
    .menu   (menu),
    .mode_q (sys_mode),
    .fmt_q  (fmt_code),
    .freq_q (freq_code),
    .fl_go  (fl_go),
    .fl_two (fl_two)
  );

  flash_seq #(.FLASH_LEN(FLASH_LEN)) i_flash (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (fl_go),
    .two   (fl_two),
    .busy  (fl_busy),
    .lit   (fl_lit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blink_cnt <= '0;
      blink_on  <= 1'b1;
    end else if (blink_cnt == BLINK_LAST) begin
      blink_cnt <= '0;
      blink_on  <= !blink_on;
    end else begin
      blink_cnt <= blink_cnt + 1'b1;
    end
  end

  always_comb begin
    if (fl_busy) begin
      led = {LED_W{fl_lit}};
    end else begin
      led      = '0;
      led[menu] = blink_on;
      led[5]   = (sys_mode == SYS_GENLOCK);
      led[6]   = (sys_mode == SYS_PASS);
      led[7]   = (sys_mode == SYS_STAND);
    end
  end
endmodule

// File: rtl/menu_ctrl_chk.sv
module menu_ctrl_chk
  import menu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] led,
  input logic [1:0] sys_mode,
  input logic [3:0] fmt_code,
  input logic [2:0] freq_code,
  input logic       busy,
  input logic [3:0] press
);
  p_mode_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_mode != 2'd3);

  p_mode_leds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (led[7:5] == (3'b001 << sys_mode)));

  p_menu_led_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ($onehot0(led[3:0]) && !led[4]));

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code <= 4'd11) && (freq_code <= 3'd4));

  p_pair_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ok(fmt_code, freq_code));

  p_flash_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((led == 8'hFF) || (led == 8'h00)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sys_mode) && $stable(fmt_code) && $stable(freq_code)));

  p_press_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|press) |=> ((press & $past(press)) == 4'b0000));
endmodule

bind mode_menu_ctrl menu_ctrl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .led       (led),
  .sys_mode  (sys_mode),
  .fmt_code  (fmt_code),
  .freq_code (freq_code),
  .busy      (fl_busy),
  .press     (press)
);

// File: tb/test_mode_menu_ctrl.sv
module test_mode_menu_ctrl;
  localparam int DEB   = 4;
  localparam int BLINK = 8;
  localparam int FLASH = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btn_raw = '0;
  logic       cfg_ok = 1'b1;
  logic [7:0] led;
  logic [1:0] sys_mode;
  logic [3:0] fmt_code;
  logic [2:0] freq_code;

  int n_chk = 0;
  int n_bad = 0;
  logic clr = 1'b0;
  int rises = 0;
  int lit_cycles = 0;
  logic prev_full = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mode_menu_ctrl #(.DEB_LEN(DEB), .BLINK_LEN(BLINK), .FLASH_LEN(FLASH)) i_mode_menu_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .cfg_ok(cfg_ok),
    .led(led), .sys_mode(sys_mode), .fmt_code(fmt_code), .freq_code(freq_code)
  );

  always @(posedge clk) begin
    if (clr) begin
      rises      <= 0;
      lit_cycles <= 0;
      prev_full  <= 1'b0;
    end else begin
      prev_full <= (led == 8'hFF);
      if (led == 8'hFF && !prev_full) rises <= rises + 1;
      if (led == 8'hFF) lit_cycles <= lit_cycles + 1;
    end
  end

  // {req, button, cfg_ok, flashes, mode, fmt, freq, menu after}
  localparam int NSTEP = 29;
  localparam logic [19:0] STEPS [NSTEP] = '{
    {4'd2, 2'd2, 1'b1, 2'd0, 2'd2, 4'd0,  3'd0, 2'd2}, // R2 open format
    {4'd6, 2'd2, 1'b1, 2'd0, 2'd2, 4'd0,  3'd0, 2'd2}, // R6 up
    {4'd7, 2'd1, 1'b1, 2'd1, 2'd2, 4'd1,  3'd0, 2'd0}, // R7 good pair
    {4'd2, 2'd2, 1'b1, 2'd0, 2'd2, 4'd1,  3'd0, 2'd2}, // R2
    {4'd6, 2'd3, 1'b1, 2'd0, 2'd2, 4'd1,  3'd0, 2'd2}, // R6 down
    {4'd6, 2'd3, 1'b1, 2'd0, 2'd2, 4'd1,  3'd0, 2'd2}, // R6 wrap to 11
    {4'd7, 2'd1, 1'b1, 2'd2, 2'd2, 4'd1,  3'd0, 2'd0}, // R7 bad pair
    {4'd2, 2'd3, 1'b1, 2'd0, 2'd2, 4'd1,  3'd0, 2'd3}, // R2 open freq
    {4'd6, 2'd3, 1'b1, 2'd0, 2'd2, 4'd1,  3'd0, 2'd3}, // R6 wrap to 4
    {4'd7, 2'd1, 1'b1, 2'd1, 2'd2, 4'd11, 3'd4, 2'd0}, // R7 pair from pending
    {4'd2, 2'd3, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd3}, // R2
    {4'd6, 2'd2, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd3}, // R6 wrap up to 0
    {4'd6, 2'd0, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd0}, // R6 cancel
    {4'd2, 2'd3, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd3}, // R2
    {4'd6, 2'd1, 1'b1, 2'd1, 2'd2, 4'd11, 3'd4, 2'd0}, // R6 cancel restored
    {4'd2, 2'd0, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd1}, // R2 open mode
    {4'd4, 2'd1, 1'b1, 2'd1, 2'd0, 4'd11, 3'd4, 2'd0}, // R4 genlock
    {4'd2, 2'd2, 1'b1, 2'd0, 2'd0, 4'd11, 3'd4, 2'd2}, // R2
    {4'd6, 2'd2, 1'b1, 2'd0, 2'd0, 4'd11, 3'd4, 2'd2}, // R6 wrap 11 to 0
    {4'd7, 2'd1, 1'b1, 2'd2, 2'd0, 4'd11, 3'd4, 2'd0}, // R7 not standalone
    {4'd2, 2'd0, 1'b1, 2'd0, 2'd0, 4'd11, 3'd4, 2'd1}, // R2
    {4'd4, 2'd2, 1'b0, 2'd2, 2'd0, 4'd11, 3'd4, 2'd0}, // R4 reconfig fails
    {4'd2, 2'd0, 1'b1, 2'd0, 2'd0, 4'd11, 3'd4, 2'd1}, // R2
    {4'd4, 2'd2, 1'b1, 2'd1, 2'd1, 4'd11, 3'd4, 2'd0}, // R4 pass-through
    {4'd5, 2'd1, 1'b1, 2'd2, 2'd1, 4'd11, 3'd4, 2'd0}, // R5 datapath
    {4'd2, 2'd0, 1'b1, 2'd0, 2'd1, 4'd11, 3'd4, 2'd1}, // R2
    {4'd4, 2'd3, 1'b1, 2'd1, 2'd2, 4'd11, 3'd4, 2'd0}, // R4 standalone
    {4'd2, 2'd0, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd1}, // R2
    {4'd4, 2'd0, 1'b1, 2'd0, 2'd2, 4'd11, 3'd4, 2'd0}  // R4 cancel
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int b);
    btn_raw[b] = 1'b1;
    cycles(10);
    btn_raw[b] = 1'b0;
    cycles(10);
  endtask

  task automatic clear_mon();
    clr = 1'b1;
    cycles(1);
    clr = 1'b0;
  endtask

  task automatic check_leds(input string req, input int mn, input int md);
    int on_cnt [4];
    int bad_side = 0;
    for (int k = 0; k < 4; k++) on_cnt[k] = 0;
    for (int c = 0; c < 2 * BLINK; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (led[k]) on_cnt[k]++;
      if (led[4] || (led[7:5] != (3'b001 << md))) bad_side++;
    end
    check(req, "blink on-cycles of active menu led", on_cnt[mn], BLINK);
    check(req, "other menu led on-cycles",
          on_cnt[0] + on_cnt[1] + on_cnt[2] + on_cnt[3] - on_cnt[mn], 0);
    check("R3", "mode leds / led4 mismatches", bad_side, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    cycles(5);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check("R1", "sys_mode", sys_mode, 2);
    check("R1", "fmt_code", fmt_code, 0);
    check("R1", "freq_code", freq_code, 0);
    check_leds("R1", 0, 2);

    // R10 short glitch produces no press
    btn_raw[0] = 1'b1;
    cycles(2);
    btn_raw[0] = 1'b0;
    cycles(20);
    check_leds("R10", 0, 2);

    // main table
    for (int s = 0; s < NSTEP; s++) begin
      logic [19:0] v;
      string rq;
      v = STEPS[s];
      rq = $sformatf("R%0d step %0d", v[19:16], s);
      cfg_ok = v[13];
      clear_mon();
      press(int'(v[15:14]));
      cycles(40);
      check(rq, "flash count", rises, int'(v[12:11]));
      check(rq, "sys_mode", sys_mode, int'(v[10:9]));
      check(rq, "fmt_code", fmt_code, int'(v[8:5]));
      check(rq, "freq_code", freq_code, int'(v[4:2]));
      check_leds(rq, int'(v[1:0]), int'(v[10:9]));
    end
    cfg_ok = 1'b1;

    // R8 flash shape: two flashes of FLASH cycles lit each
    clear_mon();
    press(1);
    cycles(40);
    check("R8", "flash rises", rises, 2);
    check("R8", "lit cycles", lit_cycles, 2 * FLASH);

    // R9 press during flash ignored
    clear_mon();
    press(1);
    btn_raw[0] = 1'b1;
    cycles(6);
    btn_raw[0] = 1'b0;
    cycles(40);
    check("R9", "flash rises", rises, 2);
    check_leds("R9", 0, 2);

    // R1 reset from a non-default state
    press(0);
    cycles(30);
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    check("R1", "sys_mode after reset", sys_mode, 2);
    check("R1", "fmt_code after reset", fmt_code, 0);
    check("R1", "freq_code after reset", freq_code, 0);
    check_leds("R1", 0, 2);

    done = 1'b1;
    report();
  end
endmodule